// File: doc/BRIEF.md
# PCM Serial Frame Port

This block moves one 8-bit companded voice sample per frame in each direction over a four-wire synchronous serial link. On the transmit side, a parallel byte is captured when the transmit frame sync rises. The byte is then shifted out most significant bit first, one bit per bit-clock period. The serial output is only enabled for those eight bit periods. Outside that window the line floats, and an external pull-up holds it high. On the receive side, bits arriving on the serial input are collected on falling bit-clock edges, starting at a separate receive frame sync. Each complete byte is presented in parallel with a one-cycle valid pulse.

The port runs on a fast system clock and treats the bit clock, both syncs, the serial input and the power-down pin as asynchronous. All of them pass through one synchroniser chain of equal depth, so their relative timing is preserved. Two conditions stop the link. The first is a stall: the bit clock or the transmit sync stops toggling for a programmable number of system cycles. This puts the port into a power-saving state. The second is an active-low power-down input, which forces the port into power-down. In either case a byte in flight is abandoned. Once the link is running again, nothing moves until the next frame sync rises.

Top module: `pcm_frame_port`

## Requirements
- R1: After reset, ser_oe is 0, ser_out reads 1, rx_valid is 0 and pwr_save is 0.
- R2: On a rising edge of tx_sync_in, tx_byte is captured and its bit 7 is driven on ser_out. Each following rising bit-clock edge presents the next lower bit, down to bit 0.
- R3: ser_oe is 1 for exactly the eight bit periods that begin at the transmit sync rise, and it drops at the ninth rising bit-clock edge. Whenever ser_oe is 0, ser_out reads 1 (the pulled-up line).
- R4: ser_in is sampled on falling bit-clock edges. The first sample after a rising edge of rx_sync_in is bit 7. After the eighth sample, rx_byte holds the byte and rx_valid is high for exactly one system cycle.
- R5: If rx_sync_in rises again before eight bits have been taken, the partial byte is dropped with no valid pulse, and reception restarts from bit 7.
- R6: If neither edge of bclk_in, or neither edge of tx_sync_in, is seen for STALL_CYCLES system cycles, pwr_save goes to 1, ser_oe goes to 0 and any transfer in progress is abandoned. pwr_save clears in the cycle where an edge is seen again on the stalled input.
- R7: While pwr_dn_n is 0, ser_oe stays 0, no rx_valid pulse occurs and transfers in progress are abandoned.
- R8: After leaving power-saving or power-down, neither direction transfers data until its own frame sync rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| tx_sync_in | input | 1 | Transmit frame sync; the rising edge marks bit 7 |
| rx_sync_in | input | 1 | Receive frame sync; the rising edge marks bit 7 |
| ser_in | input | 1 | Serial receive data |
| pwr_dn_n | input | 1 | Active-low power-down request |
| tx_byte | input | 8 | Byte to send, captured at the transmit sync rise |
| ser_out | output | 1 | Serial transmit data; reads 1 when not enabled |
| ser_oe | output | 1 | Output enable for the open-drain pad |
| rx_byte | output | 8 | Last complete received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is updated |
| pwr_save | output | 1 | High while the bit clock or transmit sync is stalled |

## Verification
A transmit bit counter that is off by one shows up in two ways. One data bit on ser_out is wrong, and the enable window is one bit period too short or too long. Both are visible within the first frame, in the bit period where the error occurs. A receive counter that drifts, or that fails to restart on a fresh sync, gives a wrong byte or a missing or extra valid pulse by the end of that same frame. A stall or power-down flag that is stuck shows up differently. Either ser_oe stays high through a stalled clock or a power-down, or ser_oe never comes back after a fresh sync. Either way the fault appears within one stall timeout or one frame.

// File: rtl/pcm_port_pkg.sv
// Package: shared widths, channel indices and byte type for the PCM frame port.
// Assumes an 8-bit sample; the channel indices fix the order of the synchroniser bus.
package pcm_port_pkg;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W);
    localparam int NUM_CH  = 5;
    localparam int CH_BCLK = 0;
    localparam int CH_TXS  = 1;
    localparam int CH_RXS  = 2;
    localparam int CH_SDIN = 3;
    localparam int CH_PDN  = 4;
    localparam int NUM_WATCH = 2;

    typedef logic [BYTE_W-1:0] pcm_byte_t;
endpackage

// File: rtl/pcm_sync_edge.sv
// Module: multi-bit synchroniser with rise/fall detection.
// Every channel has the same depth, so signals that change together on the
// pins are seen together inside. Assumes inputs are slower than clk.
module pcm_sync_edge #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    genvar ch;
    generate
        for (ch = 0; ch < WIDTH; ch++) begin : g_ch
            logic [STAGES-1:0] chain;
            logic              prev;

            // Shift the pin value through the synchroniser stages.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in[ch]};
            end

            // Hold the previous synchronised level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) prev <= 1'b0;
                else        prev <= chain[STAGES-1];
            end

            assign level[ch] = chain[STAGES-1];
            assign rise[ch]  = chain[STAGES-1] & ~prev;
            assign fall[ch]  = ~chain[STAGES-1] & prev;
        end
    endgenerate
endmodule

// File: rtl/pcm_stall_mon.sv
// Module: per-signal inactivity timers. A channel counts system cycles since
// its last edge and saturates at LIMIT. The stall flag is released in the
// very cycle an edge appears, so that edge can already start a transfer.
module pcm_stall_mon #(
    parameter int N     = 2,
    parameter int LIMIT = 8192
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] edge_seen,
    output logic         stalled
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [N-1:0] chan_stall;

    genvar w;
    generate
        for (w = 0; w < N; w++) begin : g_watch
            logic [CW-1:0] idle_cnt;

            // Count idle cycles; restart on an edge, stop at the limit.
            always_ff @(posedge clk) begin
                if (!rst_n)                        idle_cnt <= '0;
                else if (edge_seen[w])             idle_cnt <= '0;
                else if (idle_cnt != CW'(LIMIT))   idle_cnt <= idle_cnt + 1'b1;
            end

            assign chan_stall[w] = (idle_cnt == CW'(LIMIT)) && !edge_seen[w];
        end
    endgenerate

    assign stalled = |chan_stall;
endmodule

// File: rtl/pcm_tx_shift.sv
// Module: transmit shifter. Loads the byte on a frame-sync rise and drives
// bit 7 at once. Each later bit-clock rise moves to the next bit, but only
// after a bit-clock fall has been seen since the last move, so a sync that
// lands a system cycle ahead of its bit-clock rise cannot skip a bit.
module pcm_tx_shift
    import pcm_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active,
    input  logic      sync_rise,
    input  logic      bclk_rise,
    input  logic      bclk_fall,
    input  pcm_byte_t load_byte,
    output logic      out_bit,
    output logic      out_en
);
    pcm_byte_t        shreg;
    logic [CNT_W-1:0] pos;
    logic             half_seen;

    // Frame control: load on sync, shift on qualified bit-clock rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            pos       <= '0;
            half_seen <= 1'b0;
            out_en    <= 1'b0;
        end else if (!active) begin
            pos       <= '0;
            half_seen <= 1'b0;
            out_en    <= 1'b0;
        end else if (sync_rise) begin
            shreg     <= load_byte;
            pos       <= '0;
            half_seen <= 1'b0;
            out_en    <= 1'b1;
        end else if (out_en) begin
            if (bclk_fall) half_seen <= 1'b1;
            if (bclk_rise && half_seen) begin
                half_seen <= 1'b0;
                if (pos == CNT_W'(BYTE_W - 1)) begin
                    out_en <= 1'b0;
                end else begin
                    pos   <= pos + 1'b1;
                    shreg <= {shreg[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign out_bit = shreg[BYTE_W-1];
endmodule

// File: rtl/pcm_rx_shift.sv
// Module: receive shifter. A frame-sync rise arms it and clears the bit
// count, dropping any partial byte. Each bit-clock fall shifts in one bit;
// the eighth publishes the byte with a one-cycle valid and disarms.
module pcm_rx_shift
    import pcm_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active,
    input  logic      sync_rise,
    input  logic      bclk_fall,
    input  logic      din,
    output pcm_byte_t byte_q,
    output logic      valid
);
    pcm_byte_t        shreg;
    logic [CNT_W-1:0] cnt;
    logic             busy;

    // Bit collection and byte hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            cnt    <= '0;
            busy   <= 1'b0;
            byte_q <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (!active) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (sync_rise) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy && bclk_fall) begin
                shreg <= {shreg[BYTE_W-2:0], din};
                cnt   <= cnt + 1'b1;
                if (cnt == CNT_W'(BYTE_W - 1)) begin
                    byte_q <= {shreg[BYTE_W-2:0], din};
                    valid  <= 1'b1;
                    busy   <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_frame_port.sv
// Module: PCM serial frame port top. Synchronises the pins, watches for a
// stalled bit clock or transmit sync, and runs the transmit and receive
// shifters only while powered up and not stalled. Assumes clk is at least
// eight times faster than the bit clock.
module pcm_frame_port
    import pcm_port_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int STALL_CYCLES = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_in,
    input  logic             tx_sync_in,
    input  logic             rx_sync_in,
    input  logic             ser_in,
    input  logic             pwr_dn_n,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic             ser_out,
    output logic             ser_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic             rx_valid,
    output logic             pwr_save
);
    logic [NUM_CH-1:0]    pins, lvl, rise, fall;
    logic [NUM_WATCH-1:0] watch_edges;
    logic bclk_rise, bclk_fall, tx_sync_rise, rx_sync_rise;
    logic run_en, stalled, tx_bit, tx_en;

    assign pins[CH_BCLK] = bclk_in;
    assign pins[CH_TXS]  = tx_sync_in;
    assign pins[CH_RXS]  = rx_sync_in;
    assign pins[CH_SDIN] = ser_in;
    assign pins[CH_PDN]  = pwr_dn_n;

    pcm_sync_edge #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pins),
        .level(lvl), .rise(rise), .fall(fall)
    );

    assign bclk_rise    = rise[CH_BCLK];
    assign bclk_fall    = fall[CH_BCLK];
    assign tx_sync_rise = rise[CH_TXS];
    assign rx_sync_rise = rise[CH_RXS];

    logic unused_sync_bits;
    assign unused_sync_bits = ^{lvl[CH_BCLK], lvl[CH_TXS], lvl[CH_RXS],
                                fall[CH_RXS], rise[CH_SDIN], fall[CH_SDIN],
                                rise[CH_PDN], fall[CH_PDN]};

    assign watch_edges[0] = bclk_rise | bclk_fall;
    assign watch_edges[1] = tx_sync_rise | fall[CH_TXS];

    pcm_stall_mon #(.N(NUM_WATCH), .LIMIT(STALL_CYCLES)) u_stall (
        .clk(clk), .rst_n(rst_n), .edge_seen(watch_edges), .stalled(stalled)
    );

    assign run_en   = lvl[CH_PDN] && !stalled;
    assign pwr_save = stalled;

    pcm_tx_shift u_tx (
        .clk(clk), .rst_n(rst_n), .active(run_en), .sync_rise(tx_sync_rise),
        .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .load_byte(tx_byte),
        .out_bit(tx_bit), .out_en(tx_en)
    );

    pcm_rx_shift u_rx (
        .clk(clk), .rst_n(rst_n), .active(run_en), .sync_rise(rx_sync_rise),
        .bclk_fall(bclk_fall), .din(lvl[CH_SDIN]),
        .byte_q(rx_byte), .valid(rx_valid)
    );

    assign ser_oe  = tx_en;
    assign ser_out = tx_en ? tx_bit : 1'b1;
endmodule

// File: rtl/pcm_frame_port_checker.sv
// Module: temporal checks on the frame port, attached by bind.
module pcm_frame_port_checker (
    input logic clk,
    input logic rst_n,
    input logic active,
    input logic tx_rise,
    input logic bclk_fall,
    input logic ser_oe,
    input logic rx_valid,
    input logic pwr_save
);
    assert_oe_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_oe) |-> $past(tx_rise));

    assert_valid_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bclk_fall));

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_save_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_save |=> !ser_oe);

    assert_down_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !ser_oe);

    assert_restart_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_oe) |-> $past(active));
endmodule

bind pcm_frame_port pcm_frame_port_checker u_chk (
    .clk(clk), .rst_n(rst_n), .active(run_en), .tx_rise(tx_sync_rise),
    .bclk_fall(bclk_fall), .ser_oe(ser_oe), .rx_valid(rx_valid),
    .pwr_save(pwr_save)
);

// File: tb/pcm_frame_port_test.sv
// Bench: vector table of tx/rx byte pairs, then directed reset, restart,
// stall and power-down cases. One bit-clock period is 16 system clocks.
module pcm_frame_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 8;
    localparam int STALL      = 800;
    localparam int NVEC       = 6;
    localparam logic [15:0] VEC [NVEC] = '{16'hA53C, 16'h00FF, 16'hFF00,
                                           16'h8001, 16'h0180, 16'h5AC3};

    logic clk = 0, rst_n = 0;
    logic bclk = 0, txs = 0, rxs = 0, sdin = 0, pdn_n = 1;
    logic [7:0] txb = 0;
    logic ser_out, ser_oe, rx_valid, pwr_save;
    logic [7:0] rx_byte;

    int checks = 0, fails = 0, vcount = 0, cycles = 0;
    logic [7:0] last_rx = 0;

    pcm_frame_port #(.SYNC_STAGES(2), .STALL_CYCLES(STALL)) uut (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .tx_sync_in(txs),
        .rx_sync_in(rxs), .ser_in(sdin), .pwr_dn_n(pdn_n), .tx_byte(txb),
        .ser_out(ser_out), .ser_oe(ser_oe), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .pwr_save(pwr_save)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record every received byte away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            vcount++;
            last_rx = rx_byte;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One bit period; samples the outputs just before the falling bit clock.
    task automatic bit_period(input logic ts, input logic rs, input logic d,
                              output logic oe_s, output logic out_s);
        @(negedge clk);
        bclk = 1; txs = ts; rxs = rs; sdin = d;
        wait_neg(HALF_BIT - 1);
        oe_s = ser_oe; out_s = ser_out;
        @(negedge clk);
        bclk = 0;
        wait_neg(HALF_BIT - 1);
    endtask

    // Full 32-bit frame; receive byte starts at bit rx_start.
    task automatic run_frame(input logic [7:0] tx, input logic [7:0] rx, input int rx_start);
        logic oe_s, out_s, d;
        int v0;
        v0 = vcount;
        txb = tx;
        for (int k = 0; k < 32; k++) begin
            if (k >= rx_start && k < rx_start + 8) d = rx[7 - (k - rx_start)];
            else d = k[0];
            bit_period(k == 0, (k == 0) || (k == rx_start), d, oe_s, out_s);
            if (k < 8) begin
                check(oe_s == 1'b1, "R3 oe in slot", oe_s, 1);
                check(out_s == tx[7-k], "R2 tx bit", out_s, tx[7-k]);
            end else if (k < 10) begin
                check(oe_s == 1'b0, "R3 oe after slot", oe_s, 0);
                check(out_s == 1'b1, "R3 idle line", out_s, 1);
            end
        end
        check(vcount == v0 + 1, (rx_start == 0) ? "R4 valid count" : "R5 valid count",
              vcount - v0, 1);
        check(last_rx == rx, (rx_start == 0) ? "R4 rx byte" : "R5 rx byte", last_rx, rx);
    endtask

    // Bit periods with no sync; the port must stay silent.
    task automatic quiet_periods(input int n, input string req);
        logic oe_s, out_s;
        int v0, oe_hits;
        v0 = vcount; oe_hits = 0;
        for (int k = 0; k < n; k++) begin
            bit_period(1'b0, 1'b0, k[0], oe_s, out_s);
            if (oe_s) oe_hits++;
        end
        check(oe_hits == 0, req, oe_hits, 0);
        check(vcount == v0, req, vcount - v0, 0);
    endtask

    initial begin
        logic oe_s, out_s;
        wait_neg(4);
        // R1: reset state
        check(ser_oe == 0, "R1 oe", ser_oe, 0);
        check(ser_out == 1, "R1 ser_out", ser_out, 1);
        check(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
        check(pwr_save == 0, "R1 pwr_save", pwr_save, 0);
        rst_n = 1;
        wait_neg(4);

        // R2 R3 R4: vector table
        for (int i = 0; i < NVEC; i++) run_frame(VEC[i][15:8], VEC[i][7:0], 0);

        // R5: receive restart after four bits
        run_frame(8'h3E, 8'hB7, 4);
        run_frame(8'hC1, 8'h4D, 7);

        // R6: bit clock stops mid-byte
        txb = 8'hF0;
        for (int k = 0; k < 3; k++) bit_period(k == 0, k == 0, 1'b1, oe_s, out_s);
        check(oe_s == 1, "R6 oe before stall", oe_s, 1);
        wait_neg(STALL + 50);
        check(pwr_save == 1, "R6 pwr_save", pwr_save, 1);
        check(ser_oe == 0, "R6 oe stalled", ser_oe, 0);
        // R8: clocks return, no sync yet
        quiet_periods(16, "R8 after stall");
        run_frame(8'h69, 8'h96, 0);
        check(pwr_save == 0, "R6 recovered", pwr_save, 0);

        // R6: transmit sync alone stops
        quiet_periods(60, "R6 sync stall quiet");
        check(pwr_save == 1, "R6 sync stall", pwr_save, 1);
        run_frame(8'h12, 8'h34, 0);

        // R7: power-down mid-byte
        txb = 8'h0F;
        for (int k = 0; k < 3; k++) bit_period(k == 0, k == 0, 1'b0, oe_s, out_s);
        pdn_n = 0;
        quiet_periods(10, "R7 power down");
        pdn_n = 1;
        quiet_periods(16, "R8 after power down");
        run_frame(8'hE7, 8'h7E, 0);

        finish_run();
    end
endmodule